// File: doc/BRIEF.md
# Fixed-Point Rounding Shifter

This block shifts a 64-bit operand right by 0 to 63 places and rounds the result according to the bits that fall off the bottom. The shift can be logical or arithmetic. In arithmetic mode the operand is first sign-extended from a selectable element width of 8, 16, 32 or 64 bits. One of four rounding modes decides whether 1 is added to the truncated value: round-to-nearest-up, round-to-nearest-even, round-down, or round-to-odd.

The rounding decision uses three inputs: the most significant discarded bit (the guard), the OR of every discarded bit below it (the sticky), and the lsb of the truncated value. The increment is also driven out on its own pin, so that neighbouring fixed-point units (averaging adders, narrowing clippers, fractional multipliers) can reuse the decision without building a second copy. A parameter selects whether the outputs are registered or purely combinational. The bench uses the registered default, which has one cycle of latency.

Top module: `fxp_round_shifter`

## Requirements
- R1: A shift amount of 0 never produces an increment, so the result equals the operand (logical) or the sign-extended operand (arithmetic).
- R2: Rounding mode code 2'b10 (round-down) always gives an increment of 0.
- R3: Rounding mode code 2'b00 (nearest-up) gives an increment equal to operand bit shift-1. This also holds at the largest shift of 63.
- R4: Rounding mode code 2'b01 (nearest-even) gives an increment equal to operand bit shift-1 AND (sticky OR truncated lsb). Sticky is the OR of operand bits shift-2 down to 0.
- R5: Rounding mode code 2'b11 (round-to-odd) gives an increment of 1 only when the truncated lsb is 0 and at least one discarded operand bit is set.
- R6: For a shift of 1 the sticky term is 0, so the single discarded bit acts only as the guard.
- R7: With the arithmetic select low (logical shift), vacated upper bits are filled with zeros and the element-width code has no effect.
- R8: With the arithmetic select high, the operand is sign-extended from the width coded 00=8, 01=16, 10=32, 11=64 bits and then shifted arithmetically. Guard and sticky are taken from the operand as presented, before sign extension.
- R9: The result is the truncated value plus the increment, wrapping modulo 2^64.
- R10: In the registered variant, the result and increment appear one clock after the inputs, and both read 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| operand_i | input | 64 | Value to shift |
| shamt_i | input | 6 | Shift distance, 0 to 63 |
| arith_i | input | 1 | 1 = arithmetic shift with sign extension, 0 = logical shift |
| ew_sel_i | input | 2 | Element width for sign extension: 00=8, 01=16, 10=32, 11=64 |
| rnd_mode_i | input | 2 | 00 nearest-up, 01 nearest-even, 10 down, 11 odd |
| result_o | output | 64 | Rounded shifted value |
| rnd_inc_o | output | 1 | Rounding increment that was applied |

## Verification
Sign extension and rounding can act on the same operand in the same cycle. When the shift reaches past the element width, the discarded bits of the raw operand differ from those of the extended value, and the increment can then carry through an all-ones extended result and wrap it to zero. The bench provokes both effects with short negative elements shifted arithmetically past their width, and with an all-ones operand shifted by 1. It judges both the wrapped result and the raw-operand guard against a bit-by-bit reference model. A sweep over every shift, width, mode and shift kind with random operands then compares each vector against the same model.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
   typedef enum logic [1:0] {
      RND_NEAR_UP   = 2'd0,
      RND_NEAR_EVEN = 2'd1,
      RND_DOWN      = 2'd2,
      RND_ODD       = 2'd3
   } rnd_mode_e;
endpackage

// File: rtl/fxr_sign_ext.sv
module fxr_sign_ext #(
   parameter int DATA_W   = 64,
   parameter int EW_SEL_W = 2
) (
   input  logic [DATA_W-1:0]   op_i,
   input  logic                arith_i,
   input  logic [EW_SEL_W-1:0] ew_i,
   output logic [DATA_W-1:0]   ext_o
);
   localparam int NUM_EW = $clog2(DATA_W / 8) + 1;

   if (NUM_EW > (1 << EW_SEL_W)) begin : g_bad_sel
      $error("element-width select too narrow for DATA_W");
   end

   logic [DATA_W-1:0] cand [NUM_EW];

   for (genvar k = 0; k < NUM_EW; k++) begin : g_ew
      localparam int EW = 8 << k;
      if (EW >= DATA_W) begin : g_full
         assign cand[k] = op_i;
      end else begin : g_part
         assign cand[k] = {{(DATA_W - EW){op_i[EW-1]}}, op_i[EW-1:0]};
      end
   end

   always_comb begin
      ext_o = op_i;
      if (arith_i) begin
         ext_o = cand[NUM_EW-1];
         for (int k = 0; k < NUM_EW; k++) begin
            if (int'(ew_i) == k) ext_o = cand[k];
         end
      end
   end
endmodule

// File: rtl/fxr_shift.sv
module fxr_shift #(
   parameter int DATA_W = 64,
   parameter int SH_W   = 6
) (
   input  logic [DATA_W-1:0] ext_i,
   input  logic              arith_i,
   input  logic [SH_W-1:0]   sh_i,
   output logic [DATA_W-1:0] trunc_o
);
   always_comb begin
      if (arith_i) trunc_o = DATA_W'($signed(ext_i) >>> sh_i);
      else         trunc_o = ext_i >> sh_i;
   end
endmodule

// File: rtl/fxr_round_inc.sv
module fxr_round_inc
   import fxr_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int SH_W   = 6
) (
   input  logic [DATA_W-1:0] op_i,
   input  logic [SH_W-1:0]   sh_i,
   input  rnd_mode_e         mode_i,
   input  logic              lsb_i,
   output logic              inc_o
);
   logic [DATA_W-1:0] below_sh;
   logic [DATA_W-1:0] guard_msk;
   logic              guard;
   logic              sticky;

   // thermometer of discarded positions; its top bit marks the guard
   assign below_sh  = ~({DATA_W{1'b1}} << sh_i);
   assign guard_msk = below_sh ^ (below_sh >> 1);
   assign guard     = |(op_i & guard_msk);
   assign sticky    = |(op_i & (below_sh >> 1));

   always_comb begin
      unique case (mode_i)
         RND_NEAR_UP:   inc_o = guard;
         RND_NEAR_EVEN: inc_o = guard & (sticky | lsb_i);
         RND_DOWN:      inc_o = 1'b0;
         RND_ODD:       inc_o = ~lsb_i & (guard | sticky);
         default:       inc_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/fxp_round_shifter.sv
module fxp_round_shifter
   import fxr_pkg::*;
#(
   parameter int  DATA_W   = 64,
   parameter int  EW_SEL_W = 2,
   parameter bit  OUT_REG  = 1'b1,
   localparam int SH_W     = $clog2(DATA_W)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [DATA_W-1:0]   operand_i,
   input  logic [SH_W-1:0]     shamt_i,
   input  logic                arith_i,
   input  logic [EW_SEL_W-1:0] ew_sel_i,
   input  logic [1:0]          rnd_mode_i,
   output logic [DATA_W-1:0]   result_o,
   output logic                rnd_inc_o
);
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 8");
   end

   rnd_mode_e         mode;
   logic [DATA_W-1:0] ext_c;
   logic [DATA_W-1:0] trunc_c;
   logic [DATA_W-1:0] sum_c;
   logic              inc_c;

   assign mode = rnd_mode_e'(rnd_mode_i);

   fxr_sign_ext #(.DATA_W(DATA_W), .EW_SEL_W(EW_SEL_W)) i_sext (
      .op_i   (operand_i),
      .arith_i(arith_i),
      .ew_i   (ew_sel_i),
      .ext_o  (ext_c)
   );

   fxr_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) i_shift (
      .ext_i  (ext_c),
      .arith_i(arith_i),
      .sh_i   (shamt_i),
      .trunc_o(trunc_c)
   );

   fxr_round_inc #(.DATA_W(DATA_W), .SH_W(SH_W)) i_rinc (
      .op_i  (operand_i),
      .sh_i  (shamt_i),
      .mode_i(mode),
      .lsb_i (trunc_c[0]),
      .inc_o (inc_c)
   );

   assign sum_c = trunc_c + DATA_W'(inc_c);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            result_o  <= '0;
            rnd_inc_o <= 1'b0;
         end else begin
            result_o  <= sum_c;
            rnd_inc_o <= inc_c;
         end
      end

      a_r10_reset_clear: assert property (@(posedge clk_i)
         $rose(rst_ni) |-> (result_o == '0 && !rnd_inc_o));
   end else begin : g_comb
      assign result_o  = sum_c;
      assign rnd_inc_o = inc_c;
   end

   a_r1_zero_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shamt_i == '0) |-> (!inc_c && trunc_c == ext_c));

   a_r2_down_no_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == RND_DOWN) |-> !inc_c);

   a_r5_odd_lsb_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == RND_ODD && trunc_c[0]) |-> !inc_c);

   a_r6_no_sticky_at_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == RND_NEAR_EVEN && shamt_i == SH_W'(1) && !trunc_c[0]) |-> !inc_c);

   a_r7_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arith_i && shamt_i != '0) |-> !trunc_c[DATA_W-1]);

   a_r9_sum_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_c && &trunc_c) |-> (sum_c == '0));
endmodule

// File: tb/test_fxp_round_shifter.sv
module test_fxp_round_shifter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op = '0;
   logic [5:0]  sh = '0;
   logic        ar = 1'b0;
   logic [1:0]  ew = '0;
   logic [1:0]  md = '0;
   logic [63:0] res;
   logic        inc;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   fxp_round_shifter i_fxp_round_shifter (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .operand_i (op),
      .shamt_i   (sh),
      .arith_i   (ar),
      .ew_sel_i  (ew),
      .rnd_mode_i(md),
      .result_o  (res),
      .rnd_inc_o (inc)
   );

   typedef struct packed {
      logic [63:0] op;
      logic [5:0]  sh;
      logic        ar;
      logic [1:0]  ew;
      logic [1:0]  md;
      logic [63:0] res;
      logic        inc;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{64'hFFFF_0000_0000_00AB, 6'd0, 1'b0, 2'd0, 2'd0, 64'hFFFF_0000_0000_00AB, 1'b0, 4'd1}, // R1
      '{64'h80, 6'd0, 1'b1, 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 4'd1},                 // R1
      '{64'h18, 6'd4, 1'b0, 2'd3, 2'd0, 64'd2, 1'b1, 4'd3},                                   // R3
      '{64'h18, 6'd4, 1'b0, 2'd3, 2'd1, 64'd2, 1'b1, 4'd4},                                   // R4 tie, odd lsb
      '{64'h28, 6'd4, 1'b0, 2'd3, 2'd1, 64'd2, 1'b0, 4'd4},                                   // R4 tie, even lsb
      '{64'h29, 6'd4, 1'b0, 2'd3, 2'd1, 64'd3, 1'b1, 4'd4},                                   // R4 above half
      '{64'h1F, 6'd4, 1'b0, 2'd3, 2'd2, 64'd1, 1'b0, 4'd2},                                   // R2
      '{64'h21, 6'd4, 1'b0, 2'd3, 2'd3, 64'd3, 1'b1, 4'd5},                                   // R5
      '{64'h31, 6'd4, 1'b0, 2'd3, 2'd3, 64'd3, 1'b0, 4'd5},                                   // R5
      '{64'h20, 6'd4, 1'b0, 2'd3, 2'd3, 64'd2, 1'b0, 4'd5},                                   // R5 exact
      '{64'h5, 6'd1, 1'b0, 2'd3, 2'd1, 64'd2, 1'b0, 4'd6},                                    // R6
      '{64'hFFFF_FFFF_FFFF_FFFF, 6'd1, 1'b1, 2'd3, 2'd0, 64'd0, 1'b1, 4'd9},                  // R9 wrap
      '{64'h80, 6'd4, 1'b0, 2'd0, 2'd2, 64'h8, 1'b0, 4'd7},                                   // R7
      '{64'h80, 6'd4, 1'b1, 2'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0, 4'd8},                 // R8 w8
      '{64'h8000, 6'd8, 1'b1, 2'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 4'd8},               // R8 w16
      '{64'h8000_0000, 6'd31, 1'b1, 2'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd8},         // R8 w32
      '{64'h80, 6'd12, 1'b1, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd8},                // R8 raw guard
      '{64'h8000_0000_0000_0000, 6'd63, 1'b0, 2'd3, 2'd0, 64'd1, 1'b0, 4'd3},                 // R3 max shift
      '{64'h4000_0000_0000_0000, 6'd63, 1'b1, 2'd3, 2'd0, 64'd1, 1'b1, 4'd3}                  // R3 max shift
   };

   // independent bit-level model
   function automatic void model(input logic [63:0] o, input int s, input logic a,
                                 input int w, input int m,
                                 output logic [63:0] r, output logic i);
      logic [63:0] e, t;
      logic g, st;
      int wb;
      wb = 8 << w;
      e = o;
      if (a) for (int b = wb; b < 64; b++) e[b] = o[wb-1];
      for (int b = 0; b < 64; b++) t[b] = (b + s < 64) ? e[b+s] : (a ? e[63] : 1'b0);
      g = (s > 0) ? o[s-1] : 1'b0;
      st = 1'b0;
      for (int b = 0; b < 63; b++) if (b + 1 < s) st = st | o[b];
      case (m)
         0: i = g;
         1: i = g & (st | t[0]);
         2: i = 1'b0;
         default: i = ~t[0] & (g | st);
      endcase
      r = t + {63'd0, i};
   endfunction

   task automatic check(input string tag, input logic [63:0] er, input logic ei);
      n_vec++;
      if (res !== er || inc !== ei) begin
         n_bad++;
         $display("FAIL %s: got result %h inc %b, expected result %h inc %b", tag, res, inc, er, ei);
      end
   endtask

   task automatic apply(input logic [63:0] o, input int s, input logic a, input int w, input int m);
      @(negedge clk);
      op = o; sh = 6'(s); ar = a; ew = 2'(w); md = 2'(m);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] er;
      logic        ei;
      // R10: outputs clear during reset even with live inputs
      op = 64'hFFFF_FFFF_FFFF_FFFF; sh = 6'd1; ar = 1'b1; ew = 2'd3; md = 2'd0;
      repeat (3) @(negedge clk);
      check("R10 reset", 64'd0, 1'b0);
      rst_n = 1'b1;
      // R10: one-cycle latency, value appears after the next edge
      @(negedge clk);
      check("R10 latency", 64'd0, 1'b1);

      for (int v = 0; v < NV; v++) begin
         apply(VECS[v].op, int'(VECS[v].sh), VECS[v].ar, int'(VECS[v].ew), int'(VECS[v].md));
         check($sformatf("R%0d table %0d", VECS[v].req, v), VECS[v].res, VECS[v].inc);
      end

      // R7: width code ignored in logical mode
      for (int w = 0; w < 4; w++) begin
         apply(64'h8000_0000_0000_8080, 5, 1'b0, w, 2);
         check("R7 width ignored", 64'h0400_0000_0000_0404, 1'b0);
      end

      // sweep: R3 R4 R5 R2 R1 R8 R9 against the model
      for (int s = 0; s < 64; s++)
         for (int w = 0; w < 4; w++)
            for (int m = 0; m < 4; m++)
               for (int a = 0; a < 2; a++) begin
                  logic [63:0] o;
                  o = {$urandom, $urandom};
                  if ((s + m) % 3 == 0) o = o & ~(64'hFFFF_FFFF_FFFF_FFFF << s) | (64'd1 << s);
                  model(o, s, a[0], w, m, er, ei);
                  apply(o, s, a[0], w, m);
                  check($sformatf("sweep m%0d (R2 R3 R4 R5 R8 R9) s%0d w%0d a%0d", m, s, w, a), er, ei);
               end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule